// File: doc/BRIEF.md
# Message Host Interface Interrupt Register Block

This block is a small memory-mapped register file behind an APB-style slave port. It holds two outbound descriptor words, a control word, an interrupt status word and a software interrupt word. It drives a single level-sensitive interrupt line. That line is a set/clear latch: particular register writes raise it and other writes drop it. It is never derived from the stored status bits.

A host driver posts descriptors and then acknowledges or clears the interrupt through the control, status or software-clear offsets. A software-set offset lets code raise the line on demand. Every access completes in one access phase with no wait states. Only the register storage, the read value composition and the interrupt latch are built here. No data movement takes place.

Top module: `msg_host_irq_regs`

## Requirements
- R1: After reset, all five stored words read as zero and `irq_o` is 0. The control word is the one exception: it reads as 0x0002_0000 because bit 17 is forced.
- R2: A write to offset 0x28 (descriptor A) stores the full 32-bit word and leaves `irq_o` unchanged. A read of 0x28 returns the stored word.
- R3: A write to offset 0x2C (descriptor B) stores the full word. If bit 29 of the written data is 1, `irq_o` is 1 after the write. A read of 0x2C returns the stored word.
- R4: A write to offset 0x4C (control) stores the word. If bit 16 of the written data is 1, `irq_o` is 0 after the write. A read of 0x4C returns the stored word with bit 17 forced to 1.
- R5: A write to offset 0x50 (interrupt status) stores the word unmodified. If bit 16 or bit 29 of the written data is 1, `irq_o` is 0 after the write. A read of 0x50 returns the stored word.
- R6: A write to offset 0x1F0 ORs the data into the software interrupt word and always sets `irq_o` to 1, even when the data is zero. Reads of 0x1F0 and 0x1F4 both return the software interrupt word.
- R7: A write to offset 0x1F4 clears the software interrupt bits that are 1 in the data. It always sets `irq_o` to 0, even when the data is zero.
- R8: Any other cycle leaves `irq_o` at its present level. This covers writes that request neither a raise nor a lower, as well as idle cycles and reads.
- R9: Within the 512-byte window, a read of an unmapped offset returns zero. A write to an unmapped offset changes no register and leaves `irq_o` unchanged.
- R10: Address bits 1:0 play no part in decoding. `pready` is 1 in every access cycle. `irq_o` changes on the clock edge that completes the write access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 9 | Byte address within the 512-byte window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| pready | output | 1 | Transfer complete, always 1 |
| irq_o | output | 1 | Latched level interrupt |

## Verification
The properties assume that a write is only effective in the cycle where `psel`, `penable` and `pwrite` are all 1. They also assume that address and data hold steady across that access phase. The interrupt properties therefore look only at that qualifying cycle and at the level one edge later. The bench drives each transfer as a setup cycle followed by a single access cycle. It changes inputs only on falling clock edges and returns to idle between transfers. As a result, each write completes exactly once and no two writes overlap.

// File: rtl/msg_host_irq_regs.sv
module msg_host_irq_regs #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              irq_o
);
  localparam int WIDX_W   = ADDR_W - 2;
  localparam int OFS_DSCA = 'h028 >> 2;
  localparam int OFS_DSCB = 'h02C >> 2;
  localparam int OFS_CTL  = 'h04C >> 2;
  localparam int OFS_IST  = 'h050 >> 2;
  localparam int OFS_SSET = 'h1F0 >> 2;
  localparam int OFS_SCLR = 'h1F4 >> 2;
  localparam int BIT_POST = 29;
  localparam int BIT_ACK  = 16;
  localparam int BIT_RDY  = 17;

  logic [DATA_W-1:0] dsc_a, dsc_b, ctl_w, ist_w, swi_w;
  logic [WIDX_W-1:0] widx;
  logic              wr_en, raise, lower;
  logic              unused_lsb;

  assign widx       = paddr[ADDR_W-1:2];
  assign unused_lsb = &{1'b0, paddr[1:0]};
  assign wr_en      = psel & penable & pwrite;
  assign pready     = 1'b1;

  always_comb begin
    raise = 1'b0;
    lower = 1'b0;
    if (wr_en) begin
      case (widx)
        WIDX_W'(OFS_DSCB): raise = pwdata[BIT_POST];
        WIDX_W'(OFS_CTL):  lower = pwdata[BIT_ACK];
        WIDX_W'(OFS_IST):  lower = pwdata[BIT_ACK] | pwdata[BIT_POST];
        WIDX_W'(OFS_SSET): raise = 1'b1;
        WIDX_W'(OFS_SCLR): lower = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsc_a <= '0;
      dsc_b <= '0;
      ctl_w <= '0;
      ist_w <= '0;
      swi_w <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en) begin
        case (widx)
          WIDX_W'(OFS_DSCA): dsc_a <= pwdata;
          WIDX_W'(OFS_DSCB): dsc_b <= pwdata;
          WIDX_W'(OFS_CTL):  ctl_w <= pwdata;
          WIDX_W'(OFS_IST):  ist_w <= pwdata;
          WIDX_W'(OFS_SSET): swi_w <= swi_w | pwdata;
          WIDX_W'(OFS_SCLR): swi_w <= swi_w & ~pwdata;
          default: ;
        endcase
      end
      if (raise)      irq_o <= 1'b1;
      else if (lower) irq_o <= 1'b0;
    end
  end

  always_comb begin
    case (widx)
      WIDX_W'(OFS_DSCA): prdata = dsc_a;
      WIDX_W'(OFS_DSCB): prdata = dsc_b;
      WIDX_W'(OFS_CTL):  prdata = ctl_w | (DATA_W'(1) << BIT_RDY);
      WIDX_W'(OFS_IST):  prdata = ist_w;
      WIDX_W'(OFS_SSET),
      WIDX_W'(OFS_SCLR): prdata = swi_w;
      default:           prdata = '0;
    endcase
  end
endmodule

module msg_host_irq_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [8:0]  paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        irq_o
);
  logic wacc;
  logic [6:0] wi;
  assign wacc = psel && penable && pwrite;
  assign wi   = paddr[8:2];

  p_dscb_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h0B && pwdata[29]) |=> irq_o);
  p_ctl_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h13 && pwdata[16]) |=> !irq_o);
  p_ctl_rdbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && wi == 7'h13) |-> prdata[17]);
  p_ist_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h14 && (pwdata[16] || pwdata[29])) |=> !irq_o);
  p_set_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h7C) |=> irq_o);
  p_clr_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h7D) |=> !irq_o);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wacc |=> $stable(irq_o));
  p_dsca_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h0A) |=> $stable(irq_o));
  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && wi == 7'h40) |=> $stable(irq_o));
  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && wi == 7'h40) |-> prdata == 32'h0);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> pready);
endmodule

bind msg_host_irq_regs msg_host_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq_o(irq_o)
);

// File: tb/msg_host_irq_regs_tb.sv
module msg_host_irq_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 9'h028, 32'hDEADBEEF, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b0, 9'h028, 32'h0,        32'hDEADBEEF, 1'b0, 4'd2},  // R2
    '{1'b1, 9'h02C, 32'h00001234, 32'h0,        1'b0, 4'd3},  // R3 no flag
    '{1'b1, 9'h02C, 32'h20000055, 32'h0,        1'b1, 4'd3},  // R3 flag
    '{1'b0, 9'h02C, 32'h0,        32'h20000055, 1'b1, 4'd3},  // R3
    '{1'b1, 9'h028, 32'h12345678, 32'h0,        1'b1, 4'd2},  // R2 hold
    '{1'b1, 9'h04C, 32'h00000003, 32'h0,        1'b1, 4'd8},  // R8
    '{1'b0, 9'h04C, 32'h0,        32'h00020003, 1'b1, 4'd4},  // R4
    '{1'b1, 9'h04C, 32'h00010000, 32'h0,        1'b0, 4'd4},  // R4 lower
    '{1'b0, 9'h04C, 32'h0,        32'h00030000, 1'b0, 4'd4},  // R4
    '{1'b1, 9'h1F0, 32'h00000005, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b1, 9'h1F0, 32'h00000030, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b0, 9'h1F4, 32'h0,        32'h00000035, 1'b1, 4'd6},  // R6
    '{1'b1, 9'h050, 32'h000000FF, 32'h0,        1'b1, 4'd5},  // R5 no lower
    '{1'b0, 9'h050, 32'h0,        32'h000000FF, 1'b1, 4'd5},  // R5
    '{1'b1, 9'h050, 32'h20000000, 32'h0,        1'b0, 4'd5},  // R5 bit29
    '{1'b1, 9'h1F0, 32'h00000000, 32'h0,        1'b1, 4'd6},  // R6 zero data
    '{1'b1, 9'h050, 32'h00010000, 32'h0,        1'b0, 4'd5},  // R5 bit16
    '{1'b1, 9'h1F0, 32'h00000100, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b1, 9'h1F4, 32'h00000011, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 9'h1F0, 32'h0,        32'h00000124, 1'b0, 4'd7},  // R7
    '{1'b1, 9'h1F0, 32'h00000000, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b1, 9'h1F4, 32'h00000000, 32'h0,        1'b0, 4'd7},  // R7 zero data
    '{1'b0, 9'h1F4, 32'h0,        32'h00000124, 1'b0, 4'd7},  // R7
    '{1'b1, 9'h1F0, 32'h00000000, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b1, 9'h100, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd9},  // R9
    '{1'b0, 9'h100, 32'h0,        32'h00000000, 1'b1, 4'd9},  // R9
    '{1'b0, 9'h02C, 32'h0,        32'h20000055, 1'b1, 4'd9},  // R9 no change
    '{1'b1, 9'h02E, 32'h0BAD0000, 32'h0,        1'b1, 4'd10}, // R10 lsb ignored
    '{1'b0, 9'h02F, 32'h0,        32'h0BAD0000, 1'b1, 4'd10}, // R10
    '{1'b1, 9'h04C, 32'h00000000, 32'h0,        1'b1, 4'd8},  // R8
    '{1'b0, 9'h04C, 32'h0,        32'h00020000, 1'b1, 4'd4}   // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [8:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        irq_o;
  int checks = 0, fails = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_host_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [8:0] a, input logic [31:0] d,
                      output logic [31:0] r);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1 r = prdata;
    check("R10 pready", {31'b0, pready}, 32'h1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    xfer(1'b0, 9'h02C, 32'h0, rd); check("R1 dscb", rd, 32'h0);
    xfer(1'b0, 9'h04C, 32'h0, rd); check("R1 ctl", rd, 32'h00020000);
    xfer(1'b0, 9'h1F0, 32'h0, rd); check("R1 swi", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].wr, VEC[i].addr, VEC[i].data, rd);
      if (!VEC[i].wr)
        check($sformatf("R%0d read vec %0d", VEC[i].req, i), rd, VEC[i].exp);
      check($sformatf("R%0d irq vec %0d", VEC[i].req, i), {31'b0, irq_o}, {31'b0, VEC[i].irq});
    end

    // R8: idle cycles hold the raised line
    repeat (4) @(negedge clk);
    check("R8 idle hold", {31'b0, irq_o}, 32'h1);

    // R10: irq changes on the edge completing the write, not before
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 9'h1F4; pwdata = 32'h0;
    @(negedge clk);
    penable = 1'b1;
    #1 check("R10 before edge", {31'b0, irq_o}, 32'h1);
    @(posedge clk); #1;
    check("R10 after edge", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;

    // R1: mid-run reset clears everything
    xfer(1'b1, 9'h1F0, 32'h0000000F, rd);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    xfer(1'b0, 9'h028, 32'h0, rd); check("R1 dsca", rd, 32'h0);
    xfer(1'b0, 9'h050, 32'h0, rd); check("R1 ist", rd, 32'h0);
    xfer(1'b0, 9'h1F4, 32'h0, rd); check("R1 swi after reset", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule